// File: doc/BRIEF.md
# Glitch-free X2 clock mode selector

This block derives the core clock qualification for an 8051-style controller from a single oscillator clock. It does not switch a clock net. It produces a clock-enable, `core_en`, which the core and its peripherals use to decide which oscillator edges count. In standard mode a divide-by-two toggle halves the rate, and each machine cycle then spans 12 oscillator periods. In X2 mode the divider is bypassed, so every oscillator cycle is an enabled core cycle and a machine cycle spans 6 of them.

A software-written request bit, `x2_req`, selects the mode. A request is applied only at the edge where the divided-by-two signal rises. This means the enable pattern never shows a stretched or shortened period at a mode change. The block also counts enabled core cycles modulo 6 as the machine-cycle phase, and it pulses a start strobe on phase 0. The phase restarts at 0 on the first cycle of a newly applied mode.

The mode controller is a two-state machine with the states MODE_STD and MODE_X2. Transition ENTER_X2 (MODE_STD to MODE_X2) is taken when the divider output is low and `x2_req` is 1. Transition LEAVE_X2 (MODE_X2 to MODE_STD) is taken when the divider output is low and `x2_req` is 0. In both cases the divider rises on that same edge.

Top module: `xclk_mode_sel`

## Requirements
- R1: While `rst_n` is low, `core_en` = 0, `mc_start` = 0 and `phase` = 0. After reset the block is in standard mode whatever `x2_req` was before.
- R2: In standard mode `core_en` is 1 on every second oscillator cycle. The first enabled cycle is the first cycle after reset release, and the pattern is high, low, high, low and so on.
- R3: In X2 mode `core_en` is 1 on every oscillator cycle.
- R4: A change of `x2_req` takes effect only where the divider rises. Count oscillator cycles from reset release, with the first cycle after release as cycle 1. The divider is high on odd cycles. If the request changes in cycle k, the new mode begins in the first odd cycle after k.
- R5: Across any mode change, two consecutive enabled cycles are never more than 2 oscillator cycles apart. A spacing shorter than one oscillator cycle is impossible.
- R6: `phase` advances by one after each enabled cycle and wraps from 5 to 0. It holds its value in cycles where `core_en` is 0.
- R7: `mc_start` is 1 exactly in enabled cycles whose `phase` is 0. This gives one strobe every 12 oscillator cycles in standard mode and every 6 in X2 mode.
- R8: On the first cycle of a newly applied mode, `phase` is 0 and `mc_start` is 1.
- R9: A request that is raised and withdrawn again before a divider rising edge has no effect. The enable pattern and the phase sequence continue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x2_req | input | 1 | Software mode request, 1 = X2, synchronous to clk_osc |
| core_en | output | 1 | Core clock enable |
| mc_start | output | 1 | Machine-cycle start strobe |
| phase | output | 3 | Machine-cycle phase, 0 to 5 |

## Verification
The bench raises and drops the mode request on both odd and even oscillator cycles. It does this because a design that applied the request on the wrong divider edge would shift the new pattern by one cycle, which produces a back-to-back or a three-cycle enable gap at the seam. The bench also pulses the request for only the unsafe half of a divider period. A selector that sampled the bit on every oscillator edge would briefly enter X2 mode and disturb the enable pattern and the phase sequence. A phase counter that kept counting through a mode change would miss the start strobe in the first cycle of the new mode. The bench also resets the block from X2 mode to check that the applied mode returns to standard.

// File: rtl/xclk_pkg.sv
package xclk_pkg;
    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_X2  = 1'b1
    } clk_mode_e;
endpackage

// File: rtl/xclk_half_div.sv
module xclk_half_div (
    input  logic clk_osc,
    input  logic rst_n,
    output logic half_q
);
    // Free-running toggle: keeps running in both modes so a rising
    // edge of the halved clock is always available to qualify a switch.
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end
endmodule

// File: rtl/xclk_mode_fsm.sv
module xclk_mode_fsm
    import xclk_pkg::*;
(
    input  logic clk_osc,
    input  logic rst_n,
    input  logic x2_req,
    input  logic half_q,
    output logic core_en,
    output logic swap_now,
    output logic x2_on
);
    clk_mode_e state_q, state_d;

    // The halved clock rises on the edge that ends a cycle with half_q low.
    logic rise_next;
    assign rise_next = ~half_q;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_STD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_STD: if (rise_next && x2_req)  state_d = MODE_X2;   // ENTER_X2
            MODE_X2:  if (rise_next && !x2_req) state_d = MODE_STD;  // LEAVE_X2
        endcase
    end

    always_comb begin
        unique case (state_q)
            MODE_STD: core_en = half_q;
            MODE_X2:  core_en = 1'b1;
        endcase
        swap_now = (state_d != state_q);
        x2_on    = (state_q == MODE_X2);
    end
endmodule

// File: rtl/xclk_phase_gen.sv
module xclk_phase_gen #(
    parameter int PHASES = 6,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic            clk_osc,
    input  logic            rst_n,
    input  logic            core_en,
    input  logic            swap_now,
    output logic [PH_W-1:0] phase,
    output logic            mc_start
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)               phase <= '0;
        else if (swap_now)        phase <= '0;
        else if (core_en) begin
            if (phase == PH_LAST) phase <= '0;
            else                  phase <= phase + PH_W'(1);
        end
    end

    assign mc_start = core_en && (phase == '0);
endmodule

// File: rtl/xclk_mode_sel.sv
module xclk_mode_sel #(
    parameter int PHASES = 6,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input  logic            clk_osc,
    input  logic            rst_n,
    input  logic            x2_req,
    output logic            core_en,
    output logic            mc_start,
    output logic [PH_W-1:0] phase
);
    logic half_q;
    logic swap_now;
    logic x2_on;

    xclk_half_div u_div (
        .clk_osc (clk_osc),
        .rst_n   (rst_n),
        .half_q  (half_q)
    );

    xclk_mode_fsm u_fsm (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .x2_req   (x2_req),
        .half_q   (half_q),
        .core_en  (core_en),
        .swap_now (swap_now),
        .x2_on    (x2_on)
    );

    xclk_phase_gen #(.PHASES(PHASES)) u_phase (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .core_en  (core_en),
        .swap_now (swap_now),
        .phase    (phase),
        .mc_start (mc_start)
    );
endmodule

// File: rtl/xclk_mode_sel_chk.sv
module xclk_mode_sel_chk #(
    parameter int PHASES = 6,
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
    input logic            clk_osc,
    input logic            rst_n,
    input logic            core_en,
    input logic            mc_start,
    input logic [PH_W-1:0] phase,
    input logic            half_q,
    input logic            x2_on
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    AST_RESET_QUIET: assert property (@(posedge clk_osc)
        !rst_n |-> (phase == '0 && !core_en && !mc_start && !x2_on)); // R1

    AST_STD_ALTERNATE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (!x2_on && core_en) |=> !core_en); // R2

    AST_X2_EVERY_CYCLE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        x2_on |-> core_en); // R3

    AST_SWITCH_ON_RISE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (x2_on != $past(x2_on)) |-> (half_q && !$past(half_q))); // R4

    AST_NO_LONG_GAP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !core_en |=> core_en); // R5

    AST_PHASE_STEP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(core_en) && (x2_on == $past(x2_on)) && ($past(phase) != PH_LAST))
        |-> (phase == $past(phase) + PH_W'(1))); // R6

    AST_PHASE_WRAP: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ($past(core_en) && (x2_on == $past(x2_on)) && ($past(phase) == PH_LAST))
        |-> (phase == '0)); // R6

    AST_PHASE_RANGE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        phase <= PH_LAST); // R6

    AST_RESTART_STROBE: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (x2_on != $past(x2_on)) |-> (phase == '0 && mc_start)); // R8
endmodule

bind xclk_mode_sel xclk_mode_sel_chk #(.PHASES(PHASES)) u_chk (
    .clk_osc  (clk_osc),
    .rst_n    (rst_n),
    .core_en  (core_en),
    .mc_start (mc_start),
    .phase    (phase),
    .half_q   (half_q),
    .x2_on    (x2_on)
);

// File: tb/xclk_mode_sel_bench.sv
module xclk_mode_sel_bench;
    logic       clk_osc = 1'b0;
    logic       rst_n   = 1'b0;
    logic       x2_req  = 1'b0;
    logic       core_en;
    logic       mc_start;
    logic [2:0] phase;

    xclk_mode_sel u_xclk_mode_sel (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .x2_req   (x2_req),
        .core_en  (core_en),
        .mc_start (mc_start),
        .phase    (phase)
    );

    always #10 clk_osc = ~clk_osc;   // 50 MHz

    int    n_vec = 0;
    int    n_bad = 0;
    int    k = 0;            // oscillator cycles since reset release
    int    sw_cyc = -1;      // cycle in which the new mode is expected to begin
    int    cur_ph = 0;
    int    last_en_k = 0;
    bit    exp_x2 = 1'b0;
    bit    sw_to = 1'b0;
    bit    prev_en = 1'b0;
    string scen = "init";

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d actual=%0d expected=%0d", req, scen, k, act, exp);
        end
    endtask

    // Advance one oscillator cycle and compare all outputs to the expectation.
    task automatic step();
        bit en_e;
        bit mc_e;
        @(negedge clk_osc);
        k++;
        if (k == sw_cyc) begin
            exp_x2 = sw_to;
            cur_ph = 0;
        end else if (prev_en) begin
            cur_ph = (cur_ph + 1) % 6;
        end
        en_e = exp_x2 ? 1'b1 : (k % 2 == 1);
        mc_e = en_e && (cur_ph == 0);
        chk(core_en == en_e, (k == sw_cyc) ? "R4" : (exp_x2 ? "R3" : "R2"), core_en, en_e);
        chk(phase == cur_ph, (k == sw_cyc) ? "R8" : "R6", phase, cur_ph);
        chk(mc_start == mc_e, "R7", mc_start, mc_e);
        if (core_en) begin
            if (last_en_k > 0)
                chk((k - last_en_k) inside {1, 2}, "R5", k - last_en_k, 2);
            last_en_k = k;
        end
        prev_en = en_e;
    endtask

    // Change the request now (a negedge); the new mode starts at the next odd cycle.
    task automatic request(input bit v);
        x2_req = v;
        sw_to  = v;
        sw_cyc = (k % 2 == 1) ? k + 2 : k + 1;
    endtask

    task automatic t_reset();
        scen = "reset";
        @(negedge clk_osc);
        rst_n  = 1'b0;
        x2_req = 1'b0;
        repeat (3) @(negedge clk_osc);
        chk(core_en == 1'b0, "R1", core_en, 0);
        chk(mc_start == 1'b0, "R1", mc_start, 0);
        chk(phase == 3'd0, "R1", phase, 0);
        rst_n = 1'b1;
        k = 0; sw_cyc = -1; cur_ph = 0; last_en_k = 0;
        exp_x2 = 1'b0; prev_en = 1'b0;
    endtask

    task automatic t_std_cadence();
        scen = "R2 standard cadence";
        repeat (26) step();
    endtask

    task automatic t_enter_x2(input bit from_odd);
        scen = from_odd ? "R4 enter X2 from odd cycle" : "R4 enter X2 from even cycle";
        if ((k % 2 == 1) != from_odd) step();
        request(1'b1);
        repeat (14) step();
    endtask

    task automatic t_leave_x2(input bit from_odd);
        scen = from_odd ? "R4 leave X2 from odd cycle" : "R4 leave X2 from even cycle";
        if ((k % 2 == 1) != from_odd) step();
        request(1'b0);
        repeat (16) step();
    endtask

    task automatic t_ignored_pulse();
        scen = "R9 withdrawn request";
        if (k % 2 == 0) step();
        x2_req = 1'b1;   // seen only at the edge where the divider falls
        step();
        x2_req = 1'b0;   // withdrawn before the next divider rise
        repeat (14) step();
    endtask

    task automatic t_reset_from_x2();
        t_enter_x2(1'b1);
        t_reset();
        scen = "R1 standard after reset from X2";
        repeat (14) step();
    endtask

    initial begin
        t_reset();
        t_std_cadence();
        t_enter_x2(1'b1);
        t_leave_x2(1'b0);
        t_enter_x2(1'b0);
        t_leave_x2(1'b1);
        t_ignored_pulse();
        t_reset_from_x2();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired in [%s]", scen);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule